// File: doc/BRIEF.md
# Masked Interrupt Arbiter with Vectored Entry

This block sits beside a processor's exception logic and decides whether an external interrupt can be taken now. It samples a set of level-sensitive request lines into a pending field. It masks that field with a per-line enable field. A global enable and a debug-mode flag then gate the result. When the masked field is nonzero, the block names the highest-numbered surviving line as the vector. It also computes the address the core must jump to.

The jump address is the entry base plus the product of two terms. The first term is the vector number added to a fixed external-interrupt code offset. The second term is a vector spacing of four bytes shifted left by the spacing exponent. An exponent of zero collapses every vector onto the base address. A small configuration register holds the global enable, the line enables and the spacing exponent, and a write strobe loads it. A take strobe from the core latches the chosen vector and address for one accepted interrupt. Saving processor state is left to the core.

Top module: `irq_vector_arb`

## Requirements
- R1: Bit i of `pend_o` equals the level that `irq_in[i]` had at the previous rising clock edge, for each i below NUM_LINES (13). A level of 1 sets the bit and a level of 0 clears it.
- R2: Bits of `irq_in` at index NUM_LINES and above (bits 13 to 15 by default) have no effect on any output.
- R3: `hard_req` is a registered flag. It is 1 exactly when at least one bit of `pend_o` is 1, whatever the line enables, global enable or debug flag are.
- R4: `int_req` is 1 only when three conditions all hold: the stored global enable is 1, `dbg_mode` is 0, and `pend_o` AND the stored line-enable field is nonzero.
- R5: `vec_num` is the index of the most significant 1 in `pend_o` AND the line-enable field. It is 0 when that masked field is zero, and in that case `int_req` is 0.
- R6: With a stored spacing exponent vs of 0, `target_pc` equals `entry_base`. With vs nonzero, `target_pc` equals `entry_base` + (CODE_OFS + `vec_num`) × 4 × 2^vs, where CODE_OFS defaults to 64.
- R7: After reset, `pend_o` and `hard_req` are 0 and `taken` is 0. The stored global enable, line-enable field and spacing exponent are all 0, so `int_req` is 0 and `target_pc` equals `entry_base`.
- R8: When `take` and `int_req` are both 1 at a rising edge, `taken` is 1 for the following cycle, and `taken_vec` and `taken_pc` hold the vector number and address from that edge. `take` with `int_req` at 0 leaves `taken` at 0.
- R9: `cfg_we` high at a rising edge loads `cfg_glob_en`, `cfg_line_en` and `cfg_vs` into the stored configuration. While `cfg_we` is low, changes on those inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | IRQ_IN_W (16) | Raw level-sensitive request lines |
| cfg_we | input | 1 | Load strobe for the configuration fields |
| cfg_glob_en | input | 1 | Global interrupt enable to store |
| cfg_line_en | input | NUM_LINES (13) | Per-line enable field to store |
| cfg_vs | input | VS_W (3) | Vector spacing exponent to store |
| entry_base | input | ADDR_W (32) | Exception entry base address |
| dbg_mode | input | 1 | Debug mode active; blocks interrupt taking |
| take | input | 1 | Core accepts the offered interrupt |
| pend_o | output | NUM_LINES (13) | Pending field |
| hard_req | output | 1 | Some line is pending, unmasked |
| int_req | output | 1 | An interrupt may be taken now |
| vec_num | output | VEC_W (4) | Selected vector number |
| target_pc | output | ADDR_W (32) | Vectored entry address |
| taken | output | 1 | One-cycle pulse after an accepted take |
| taken_vec | output | VEC_W (4) | Vector latched at the accepted take |
| taken_pc | output | ADDR_W (32) | Address latched at the accepted take |

## Verification
The properties assume that `irq_in`, `dbg_mode` and `take` are synchronous to `clk`, so every change lands between two edges. They also assume `entry_base` is stable while an address is compared. The offset sum shifted by the largest exponent must fit in ADDR_W bits, which holds for the defaults since (64+12)·512 is far below 2^32. The stimulus changes every input only at falling edges, holds `entry_base` constant, and uses exponents of 0 to 7 only. The gating cases set the global enable to 0 and the debug flag to 1 separately, each with a nonzero masked field, so that each gate is shown to block `int_req` on its own.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   // Upper bound on lines a single arbiter may serve (a 32-bit pending word).
   localparam int MAX_LINES = 32;
   // Largest spacing exponent field width supported by the address path.
   localparam int MAX_VS_W  = 4;

   // Index of the highest set bit in a word, 0 when the word is empty.
   function automatic int unsigned top_index(input logic [MAX_LINES-1:0] word);
      int unsigned idx;
      idx = 0;
      for (int unsigned b = 0; b < MAX_LINES; b++) begin
         if (word[b]) idx = b;
      end
      return idx;
   endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
   parameter int NUM_LINES = 13,
   parameter int VS_W      = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic                 glob_en_d,
   input  logic [NUM_LINES-1:0] line_en_d,
   input  logic [VS_W-1:0]      vs_d,
   output logic                 glob_en_q,
   output logic [NUM_LINES-1:0] line_en_q,
   output logic [VS_W-1:0]      vs_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glob_en_q <= 1'b0;
         line_en_q <= '0;
         vs_q      <= '0;
      end else if (we) begin
         glob_en_q <= glob_en_d;
         line_en_q <= line_en_d;
         vs_q      <= vs_d;
      end
   end
endmodule

// File: rtl/irq_pend_capture.sv
module irq_pend_capture #(
   parameter int NUM_LINES = 13,
   parameter int IRQ_IN_W  = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [IRQ_IN_W-1:0]  irq_raw,
   output logic [NUM_LINES-1:0] pend_q,
   output logic                 any_q
);
   localparam int SPARE = IRQ_IN_W - NUM_LINES;

   // One flop per supported line; lines beyond NUM_LINES are left unsampled.
   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend_q[i] <= 1'b0;
         else        pend_q[i] <= irq_raw[i];
      end
   end

   if (SPARE > 0) begin : g_spare
      logic [SPARE-1:0] unused_hi;
      assign unused_hi = irq_raw[IRQ_IN_W-1:NUM_LINES];
   end

   // Separate flop for the unmasked request so it tracks the same edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) any_q <= 1'b0;
      else        any_q <= |irq_raw[NUM_LINES-1:0];
   end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
   parameter int NUM_LINES = 13,
   parameter int VEC_W     = 4
) (
   input  logic [NUM_LINES-1:0] pend,
   input  logic [NUM_LINES-1:0] line_en,
   input  logic                 glob_en,
   input  logic                 dbg,
   output logic                 ready,
   output logic [VEC_W-1:0]     vec
);
   import irq_arb_pkg::*;

   logic [NUM_LINES-1:0] masked;
   logic [MAX_LINES-1:0] masked_wide;

   assign masked      = pend & line_en;
   assign masked_wide = MAX_LINES'(masked);

   always_comb begin
      vec = VEC_W'(top_index(masked_wide));
   end

   assign ready = glob_en & ~dbg & (|masked);
endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr #(
   parameter int ADDR_W   = 32,
   parameter int VEC_W    = 4,
   parameter int VS_W     = 3,
   parameter int CODE_OFS = 64
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [VEC_W-1:0]  vec,
   input  logic [VS_W-1:0]   vs,
   output logic [ADDR_W-1:0] pc
);
   localparam logic [ADDR_W-1:0] OFS = ADDR_W'(CODE_OFS);

   logic [ADDR_W-1:0] code;
   logic [ADDR_W-1:0] scaled;

   assign code = OFS + ADDR_W'(vec);

   // Spacing is 4 << vs bytes, so the product is a left shift by vs + 2.
   always_comb begin
      scaled = code << (32'(vs) + 32'd2);
      if (vs == '0) pc = base;
      else          pc = base + scaled;
   end
endmodule

// File: rtl/irq_vector_arb.sv
module irq_vector_arb #(
   parameter int NUM_LINES = 13,
   parameter int IRQ_IN_W  = 16,
   parameter int ADDR_W    = 32,
   parameter int VS_W      = 3,
   parameter int CODE_OFS  = 64,
   parameter int VEC_W     = $clog2(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [IRQ_IN_W-1:0]  irq_in,
   input  logic                 cfg_we,
   input  logic                 cfg_glob_en,
   input  logic [NUM_LINES-1:0] cfg_line_en,
   input  logic [VS_W-1:0]      cfg_vs,
   input  logic [ADDR_W-1:0]    entry_base,
   input  logic                 dbg_mode,
   input  logic                 take,
   output logic [NUM_LINES-1:0] pend_o,
   output logic                 hard_req,
   output logic                 int_req,
   output logic [VEC_W-1:0]     vec_num,
   output logic [ADDR_W-1:0]    target_pc,
   output logic                 taken,
   output logic [VEC_W-1:0]     taken_vec,
   output logic [ADDR_W-1:0]    taken_pc
);
   import irq_arb_pkg::*;

   // Elaboration checks on the parameter set.
   if (NUM_LINES < 2 || NUM_LINES > MAX_LINES) begin : g_bad_lines
      initial $fatal(1, "NUM_LINES out of range");
   end
   if (IRQ_IN_W < NUM_LINES) begin : g_bad_in
      initial $fatal(1, "IRQ_IN_W narrower than NUM_LINES");
   end
   if (VS_W < 1 || VS_W > MAX_VS_W) begin : g_bad_vs
      initial $fatal(1, "VS_W out of range");
   end
   if ((1 << VEC_W) < NUM_LINES) begin : g_bad_vec
      initial $fatal(1, "VEC_W too narrow");
   end

   logic                 glob_en_q;
   logic [NUM_LINES-1:0] line_en_q;
   logic [VS_W-1:0]      vs_q;

   irq_cfg_regs #(.NUM_LINES(NUM_LINES), .VS_W(VS_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we),
      .glob_en_d(cfg_glob_en), .line_en_d(cfg_line_en), .vs_d(cfg_vs),
      .glob_en_q(glob_en_q), .line_en_q(line_en_q), .vs_q(vs_q)
   );

   irq_pend_capture #(.NUM_LINES(NUM_LINES), .IRQ_IN_W(IRQ_IN_W)) u_pend (
      .clk(clk), .rst_n(rst_n), .irq_raw(irq_in),
      .pend_q(pend_o), .any_q(hard_req)
   );

   irq_prio_sel #(.NUM_LINES(NUM_LINES), .VEC_W(VEC_W)) u_sel (
      .pend(pend_o), .line_en(line_en_q), .glob_en(glob_en_q),
      .dbg(dbg_mode), .ready(int_req), .vec(vec_num)
   );

   irq_vec_addr #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .VS_W(VS_W),
                  .CODE_OFS(CODE_OFS)) u_addr (
      .base(entry_base), .vec(vec_num), .vs(vs_q), .pc(target_pc)
   );

   // Take handshake: capture the offered vector and address on acceptance.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         taken     <= 1'b0;
         taken_vec <= '0;
         taken_pc  <= '0;
      end else begin
         taken <= take & int_req;
         if (take & int_req) begin
            taken_vec <= vec_num;
            taken_pc  <= target_pc;
         end
      end
   end
endmodule

// File: rtl/irq_vector_arb_chk.sv
module irq_vector_arb_chk #(
   parameter int NUM_LINES = 13,
   parameter int IRQ_IN_W  = 16,
   parameter int ADDR_W    = 32,
   parameter int VEC_W     = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [IRQ_IN_W-1:0]  irq_in,
   input logic                 dbg_mode,
   input logic                 take,
   input logic [NUM_LINES-1:0] pend_o,
   input logic                 hard_req,
   input logic                 int_req,
   input logic [VEC_W-1:0]     vec_num,
   input logic [ADDR_W-1:0]    target_pc,
   input logic                 taken,
   input logic [VEC_W-1:0]     taken_vec,
   input logic [ADDR_W-1:0]    taken_pc
);
   p_pend_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> pend_o == $past(irq_in[NUM_LINES-1:0]));

   p_hard_any_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hard_req == (pend_o != '0));

   p_req_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      int_req |-> (!dbg_mode && pend_o != '0));

   p_vec_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
      int_req |-> pend_o[vec_num]);

   p_vec_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o == '0) |-> (vec_num == '0 && !int_req));

   p_take_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (take && int_req) |=> (taken && taken_vec == $past(vec_num)
                             && taken_pc == $past(target_pc)));

   p_take_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!(take && int_req)) |=> !taken);
endmodule

bind irq_vector_arb irq_vector_arb_chk #(
   .NUM_LINES(NUM_LINES), .IRQ_IN_W(IRQ_IN_W), .ADDR_W(ADDR_W), .VEC_W(VEC_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .dbg_mode(dbg_mode),
   .take(take), .pend_o(pend_o), .hard_req(hard_req), .int_req(int_req),
   .vec_num(vec_num), .target_pc(target_pc), .taken(taken),
   .taken_vec(taken_vec), .taken_pc(taken_pc)
);

// File: tb/irq_vector_arb_test.sv
module irq_vector_arb_test;
   localparam int CLK_PERIOD = 10;
   localparam int NL = 13;
   localparam int IW = 16;
   localparam int AW = 32;
   localparam int VW = 3;
   localparam int EW = 4;
   localparam logic [AW-1:0] BASE = 32'h1C00_0000;

   // Entry: irq(16) line_en(13) glob(1) dbg(1) vs(3) exp_int_req(1) exp_vec(4)
   localparam int NV = 10;
   localparam logic [38:0] TBL [NV] = '{
      {16'h0001, 13'h1FFF, 1'b1, 1'b0, 3'd0, 1'b1, 4'd0},
      {16'h1000, 13'h1FFF, 1'b1, 1'b0, 3'd1, 1'b1, 4'd12},
      {16'h0A00, 13'h0200, 1'b1, 1'b0, 3'd2, 1'b1, 4'd9},
      {16'h0A00, 13'h1FFF, 1'b1, 1'b0, 3'd3, 1'b1, 4'd11},
      {16'h0A00, 13'h1FFF, 1'b0, 1'b0, 3'd3, 1'b0, 4'd11},
      {16'h0A00, 13'h1FFF, 1'b1, 1'b1, 3'd3, 1'b0, 4'd11},
      {16'h0400, 13'h0300, 1'b1, 1'b0, 3'd1, 1'b0, 4'd0},
      {16'hE000, 13'h1FFF, 1'b1, 1'b0, 3'd1, 1'b0, 4'd0},
      {16'h1FFF, 13'h1FFF, 1'b1, 1'b0, 3'd7, 1'b1, 4'd12},
      {16'h0006, 13'h0006, 1'b1, 1'b0, 3'd4, 1'b1, 4'd2}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [IW-1:0] irq_in = '0;
   logic cfg_we = 1'b0, cfg_glob_en = 1'b0, dbg_mode = 1'b0, take = 1'b0;
   logic [NL-1:0] cfg_line_en = '0;
   logic [VW-1:0] cfg_vs = '0;
   logic [AW-1:0] entry_base = BASE;
   logic [NL-1:0] pend_o;
   logic hard_req, int_req, taken;
   logic [EW-1:0] vec_num, taken_vec;
   logic [AW-1:0] target_pc, taken_pc;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_vector_arb uut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we),
      .cfg_glob_en(cfg_glob_en), .cfg_line_en(cfg_line_en), .cfg_vs(cfg_vs),
      .entry_base(entry_base), .dbg_mode(dbg_mode), .take(take),
      .pend_o(pend_o), .hard_req(hard_req), .int_req(int_req),
      .vec_num(vec_num), .target_pc(target_pc), .taken(taken),
      .taken_vec(taken_vec), .taken_pc(taken_pc)
   );

   function automatic logic [AW-1:0] exp_pc(input int vec, input int vs);
      longint sp;
      sp = (vs == 0) ? 0 : 4 * (longint'(1) << vs);
      return AW'(longint'(BASE) + longint'(64 + vec) * sp);
   endfunction

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R7: reset state
      chk("R7 pend", pend_o, 0);
      chk("R7 hard_req", hard_req, 0);
      chk("R7 int_req", int_req, 0);
      chk("R7 taken", taken, 0);
      rst_n = 1'b1;
      // R7: stored config is zero, so pending lines cannot be taken
      irq_in = 16'h1FFF;
      @(negedge clk);
      chk("R7 int_req cfg zero", int_req, 0);
      chk("R7 vec masked zero", vec_num, 0);
      chk("R7 pc at base", target_pc, BASE);
      chk("R3 hard unmasked", hard_req, 1);

      // Table walk: R1 R2 R3 R4 R5 R6
      for (int k = 0; k < NV; k++) begin
         irq_in      = TBL[k][38:23];
         cfg_line_en = TBL[k][22:10];
         cfg_glob_en = TBL[k][9];
         dbg_mode    = TBL[k][8];
         cfg_vs      = TBL[k][7:5];
         cfg_we      = 1'b1;
         @(negedge clk);
         cfg_we = 1'b0;
         chk($sformatf("R1 R2 pend row %0d", k), pend_o, TBL[k][35:23]);
         chk($sformatf("R3 hard row %0d", k), hard_req, |TBL[k][35:23]);
         chk($sformatf("R4 int_req row %0d", k), int_req, TBL[k][4]);
         chk($sformatf("R5 vec row %0d", k), vec_num, TBL[k][3:0]);
         chk($sformatf("R6 pc row %0d", k), target_pc,
             exp_pc(int'(TBL[k][3:0]), int'(TBL[k][7:5])));
      end

      // R9: config inputs ignored without cfg_we
      irq_in = 16'h0010; cfg_line_en = 13'h1FFF; cfg_glob_en = 1'b1;
      cfg_vs = 3'd1; dbg_mode = 1'b0; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
      cfg_glob_en = 1'b0; cfg_line_en = '0; cfg_vs = 3'd5;
      @(negedge clk);
      chk("R9 int_req held", int_req, 1);
      chk("R9 vec held", vec_num, 4);
      chk("R9 pc held", target_pc, exp_pc(4, 1));

      // R8: accepted take
      take = 1'b1;
      @(negedge clk);
      take = 1'b0;
      chk("R8 taken pulse", taken, 1);
      chk("R8 taken_vec", taken_vec, 4);
      chk("R8 taken_pc", taken_pc, exp_pc(4, 1));
      @(negedge clk);
      chk("R8 pulse ends", taken, 0);
      // R8: take refused while debug blocks the request
      dbg_mode = 1'b1; take = 1'b1;
      @(negedge clk);
      take = 1'b0;
      chk("R8 no take in debug", taken, 0);
      chk("R8 taken_vec kept", taken_vec, 4);
      dbg_mode = 1'b0;

      // R1: clearing the level clears the bit on the next edge
      irq_in = '0;
      @(negedge clk);
      chk("R1 pend cleared", pend_o, 0);
      chk("R3 hard cleared", hard_req, 0);
      chk("R5 vec idle", vec_num, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule